// File: doc/BRIEF.md
# Serial flash command decoder

This block is the device side of a serial flash command interface. A host lowers chip select, toggles the serial clock and shifts in an opcode, then address, dummy or data bytes as the opcode requires, most significant bit first. The block samples its serial input on rising serial clock edges and changes its serial output on falling edges, so the host samples read data on its next rising edge. All serial inputs are synchronised into the system clock domain and their edges are detected there, so the serial clock must be well below the system clock.

Behind the decoder sits a small array whose index is the low bits of the 24-bit byte address, a page buffer for program data, and a status byte. Program, status write and bulk erase take effect only when chip select rises after a whole number of bytes and the write-enable latch is set. Each one then starts a busy period that lasts a programmable number of system clocks. During that period only the status read is served; every other command is dropped without effect.

Top module: `flash_cmd_dec`

## Requirements
- R1: After reset the serial output is 0, the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Opcode 0x05 streams the status byte repeatedly, MSB first, until chip select rises; bit 0 is the busy flag, bit 1 the write-enable latch, and bits 7:2 hold the value last accepted by a status write (opcode 0x01, data bits 7:2).
- R3: Opcode 0x03 takes three address bytes, high byte first, then streams array bytes from that address; the address increments after each byte and only its low MEM_AW bits select the byte, so reading wraps from the top of the array to byte 0.
- R4: Opcode 0x0B behaves as 0x03 with one dummy byte after the address; opcode 0xAB takes three dummy bytes and then streams ID_BYTE repeatedly.
- R5: Opcode 0x06 sets and opcode 0x04 clears the write-enable latch, each only if chip select rises after a multiple of eight clocks.
- R6: Opcodes 0x01, 0x02 and 0xC7 have no effect unless the write-enable latch is set; when one of them is accepted the latch clears.
- R7: Opcodes 0x01 and 0x02 need at least one data byte; a write or erase frame whose clock count is not a multiple of eight is discarded, leaving array, status and latch unchanged.
- R8: Opcode 0x02 (three address bytes, then data) programs consecutive bytes from the address, each new byte being the AND of old and new values; up to 2**PAGE_AW data bytes are kept, and later bytes overwrite the buffer from its start.
- R9: Opcode 0xC7 sets every array byte to 0xFF.
- R10: After an accepted write or erase the busy flag reads 1 for at least BUSY_CYCLES system clocks and until the array update is complete; while busy every opcode other than 0x05 is ignored, with no output data and no state change.
- R11: Unknown opcodes are ignored: the serial output stays 0 and the status is unchanged; the output is also 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the device |
| sdo | output | 1 | Serial data out of the device |

## Verification
The bench builds the block with a 64-byte array and a 16-byte page buffer, so a read near address 0xFFFF3E wraps to byte 0 and an 18-byte program overwrites the first two buffered bytes. The busy period is set to 400 system clocks, longer than the gap between the end of one frame and the opcode of the next, so commands issued right after a write land inside the busy window and their rejection is visible. A short serial clock period keeps polling loops and a full erase within a few thousand cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_WEN, K_WDIS, K_RSTAT, K_RMEM, K_RFAST,
        K_RID, K_WSTAT, K_PROG, K_ERASE
    } kind_e;

    function automatic kind_e decode(input logic [7:0] op);
        case (op)
            8'h06:   return K_WEN;
            8'h04:   return K_WDIS;
            8'h05:   return K_RSTAT;
            8'h03:   return K_RMEM;
            8'h0B:   return K_RFAST;
            8'hAB:   return K_RID;
            8'h01:   return K_WSTAT;
            8'h02:   return K_PROG;
            8'hC7:   return K_ERASE;
            default: return K_NONE;
        endcase
    endfunction

    // bytes between opcode and data phase (address plus dummy)
    function automatic logic [2:0] skip_of(input kind_e k);
        case (k)
            K_RMEM, K_RID, K_PROG: return 3'd3;
            K_RFAST:               return 3'd4;
            default:               return 3'd0;
        endcase
    endfunction

    function automatic logic has_addr(input kind_e k);
        return (k == K_RMEM) || (k == K_RFAST) || (k == K_PROG);
    endfunction

    function automatic logic is_read(input kind_e k);
        return (k == K_RSTAT) || (k == K_RMEM) || (k == K_RFAST) || (k == K_RID);
    endfunction

endpackage

// File: rtl/flash_cmd_sync.sv
module flash_cmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic sdi,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s,
    output logic cs_act,
    output logic cs_end
);
    logic [STAGES:0]   sck_q, cs_q;
    logic [STAGES-1:0] sdi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= '0;
            cs_q  <= '1;
            sdi_q <= '0;
        end else begin
            sck_q <= {sck_q[STAGES-1:0], sck};
            cs_q  <= {cs_q[STAGES-1:0], cs_n};
            sdi_q <= {sdi_q[STAGES-2:0], sdi};
        end
    end

    assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sck_fall = ~sck_q[STAGES-1] & sck_q[STAGES];
    assign sdi_s    = sdi_q[STAGES-1];
    assign cs_act   = ~cs_q[STAGES-1];
    assign cs_end   = cs_q[STAGES-1] & ~cs_q[STAGES];
endmodule

// File: rtl/flash_cmd_busy.sv
module flash_cmd_busy #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/flash_cmd_store.sv
module flash_cmd_store #(
    parameter int AW = 8,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          buf_we,
    input  logic [PW-1:0] buf_idx,
    input  logic [7:0]    buf_din,
    input  logic          go_prog,
    input  logic          go_erase,
    input  logic [AW-1:0] base,
    input  logic [PW:0]   len,
    output logic          active
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;

    typedef struct packed {
        logic          act;
        logic          erase;
        logic [AW:0]   cnt;
        logic [AW:0]   lim;
        logic [AW-1:0] base;
    } eng_t;

    logic [7:0]    mem_q [DEPTH];
    logic [7:0]    buf_q [PAGE];
    eng_t          e_d, e_q;
    logic          we;
    logic [AW-1:0] waddr;
    logic [7:0]    wdata;

    always_comb begin
        e_d   = e_q;
        we    = 1'b0;
        waddr = e_q.base + e_q.cnt[AW-1:0];
        wdata = e_q.erase ? 8'hFF : (mem_q[waddr] & buf_q[e_q.cnt[PW-1:0]]);
        if (e_q.act) begin
            we      = 1'b1;
            e_d.cnt = e_q.cnt + 1'b1;
            if (e_d.cnt == e_q.lim) e_d.act = 1'b0;
        end else if (go_erase) begin
            e_d = '{act: 1'b1, erase: 1'b1, cnt: '0, lim: (AW+1)'(DEPTH), base: '0};
        end else if (go_prog) begin
            e_d = '{act: 1'b1, erase: 1'b0, cnt: '0, lim: (AW+1)'(len), base: base};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) buf_q[buf_idx] <= buf_din;
    end

    assign rd_data = mem_q[rd_addr];
    assign active  = e_q.act;
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
    import flash_cmd_pkg::*;
#(
    parameter int         MEM_AW      = 8,
    parameter int         PAGE_AW     = 8,
    parameter int         BUSY_CYCLES = 1000,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ID_BYTE     = 8'h17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic sdo
);
    localparam int AW   = MEM_AW;
    localparam int PW   = PAGE_AW;
    localparam int PAGE = 1 << PW;

    typedef struct packed {
        logic [2:0]    bitc;
        logic [2:0]    bytec;
        logic [7:0]    sr;
        logic [7:0]    op;
        logic          ign;
        logic          in_data;
        logic [23:0]   addr;
        logic [7:0]    osr;
        logic          sdo;
        logic          wel;
        logic [5:0]    shi;
        logic [5:0]    wsr;
        logic [PW:0]   nb;
        logic [PW-1:0] widx;
    } st_t;

    st_t           st_d, st_q;
    logic          sck_rise, sck_fall, sdi_s, cs_act, cs_end;
    logic          busy, eng_active, wip;
    logic          busy_start, go_prog, go_erase, buf_we;
    logic [7:0]    byte_in, status, rd_data;
    logic [23:0]   la;
    logic [AW-1:0] rd_addr;
    kind_e         kq, kn;

    flash_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s),
        .cs_act(cs_act), .cs_end(cs_end)
    );

    flash_cmd_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(busy)
    );

    flash_cmd_store #(.AW(AW), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_we(buf_we), .buf_idx(st_q.widx), .buf_din(byte_in),
        .go_prog(go_prog), .go_erase(go_erase), .base(st_q.addr[AW-1:0]),
        .len(st_q.nb), .active(eng_active)
    );

    assign wip     = busy | eng_active;
    assign byte_in = {st_q.sr[6:0], sdi_s};
    assign kq      = decode(st_q.op);
    assign kn      = decode(byte_in);
    assign status  = {st_q.shi, st_q.wel, wip};
    // address of the byte to load: includes a low address byte completing now
    assign la      = (has_addr(kq) && st_q.bytec != 3'd0 && st_q.bytec <= 3'd3)
                     ? {st_q.addr[15:0], byte_in} : st_q.addr;
    assign rd_addr = la[AW-1:0];

    always_comb begin
        logic ld;
        st_d       = st_q;
        ld         = 1'b0;
        buf_we     = 1'b0;
        go_prog    = 1'b0;
        go_erase   = 1'b0;
        busy_start = 1'b0;
        if (!cs_act) begin
            st_d.bitc    = '0;
            st_d.bytec   = '0;
            st_d.sr      = '0;
            st_d.op      = '0;
            st_d.ign     = 1'b0;
            st_d.in_data = 1'b0;
            st_d.sdo     = 1'b0;
            st_d.nb      = '0;
            st_d.widx    = '0;
        end else begin
            if (sck_rise) begin
                st_d.sr   = byte_in;
                st_d.bitc = st_q.bitc + 3'd1;
                if (st_q.bitc == 3'd7) begin
                    if (st_q.bytec != 3'd7) st_d.bytec = st_q.bytec + 3'd1;
                    if (st_q.bytec == 3'd0) begin
                        st_d.op  = byte_in;
                        st_d.ign = (kn == K_NONE) || (wip && kn != K_RSTAT);
                        if (skip_of(kn) == 3'd0) st_d.in_data = 1'b1;
                        if (kn == K_RSTAT)       st_d.osr     = status;
                    end else if (!st_q.in_data) begin
                        st_d.addr = la;
                        if (st_q.bytec == skip_of(kq)) begin
                            st_d.in_data = 1'b1;
                            ld = !st_q.ign;
                        end
                    end else if (!st_q.ign) begin
                        ld = 1'b1;
                        if (kq == K_WSTAT || kq == K_PROG) begin
                            if (st_q.nb != (PW+1)'(PAGE)) st_d.nb = st_q.nb + 1'b1;
                        end
                        if (kq == K_WSTAT) st_d.wsr = byte_in[7:2];
                        if (kq == K_PROG) begin
                            buf_we    = 1'b1;
                            st_d.widx = st_q.widx + 1'b1;
                        end
                    end
                    if (ld) begin
                        case (kq)
                            K_RSTAT:        st_d.osr = status;
                            K_RID:          st_d.osr = ID_BYTE;
                            K_RMEM, K_RFAST: begin
                                st_d.osr  = rd_data;
                                st_d.addr = la + 24'd1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            if (sck_fall && st_q.in_data && !st_q.ign && is_read(kq)) begin
                st_d.sdo = st_q.osr[7];
                st_d.osr = {st_q.osr[6:0], 1'b0};
            end
        end
        if (cs_end && !st_q.ign && st_q.in_data && st_q.bitc == 3'd0) begin
            case (kq)
                K_WEN:  st_d.wel = 1'b1;
                K_WDIS: st_d.wel = 1'b0;
                K_WSTAT: if (st_q.wel && st_q.nb != '0) begin
                    st_d.shi   = st_q.wsr;
                    st_d.wel   = 1'b0;
                    busy_start = 1'b1;
                end
                K_PROG: if (st_q.wel && st_q.nb != '0) begin
                    go_prog    = 1'b1;
                    st_d.wel   = 1'b0;
                    busy_start = 1'b1;
                end
                K_ERASE: if (st_q.wel) begin
                    go_erase   = 1'b1;
                    st_d.wel   = 1'b0;
                    busy_start = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo = st_q.sdo;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
    parameter int BUSY_CYCLES = 1
) (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic cs_end,
    input logic sdo,
    input logic wip,
    input logic wel,
    input logic busy_start,
    input logic go_prog,
    input logic go_erase
);
    logic [31:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      since_q <= '0;
        else if (busy_start)             since_q <= 32'd1;
        else if (since_q != 32'hFFFFFFFF) since_q <= since_q + 32'd1;
    end

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo);

    assert_accept_at_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_start |-> cs_end);

    assert_wel_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (go_prog || go_erase) |-> wel);

    assert_wel_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_start |=> !wel);

    assert_wip_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_start |=> wip);

    assert_wip_min_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (since_q > 32'(BUSY_CYCLES)));

    assert_single_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_prog && go_erase));
endmodule

bind flash_cmd_dec flash_cmd_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_end(cs_end), .sdo(sdo),
    .wip(wip), .wel(st_q.wel), .busy_start(busy_start),
    .go_prog(go_prog), .go_erase(go_erase)
);

// File: tb/tb_flash_cmd_dec.sv
module tb_flash_cmd_dec;
    localparam int         AW    = 6;
    localparam int         PW    = 4;
    localparam int         BUSY  = 400;
    localparam int         HP    = 8;
    localparam int         DEPTH = 1 << AW;
    localparam int         PAGE  = 1 << PW;
    localparam logic [7:0] IDB   = 8'h5A;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic sdo;
    int   checks = 0, errors = 0, cyc = 0;

    logic [7:0] ref_mem [DEPTH];
    logic       ref_wel = 1'b0;
    logic [5:0] ref_shi = '0;
    logic [7:0] dq [$];

    flash_cmd_dec #(.MEM_AW(AW), .PAGE_AW(PW), .BUSY_CYCLES(BUSY),
                    .SYNC_STAGES(2), .ID_BYTE(IDB)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo)
    );

    // 4-unit period, 250 MHz nominal
    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] ref_status();
        return {ref_shi, ref_wel, 1'b0};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            tick(HP);
            r[i] = sdo;
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
        end
    endtask

    task automatic extra_bits(input int n);
        for (int i = 0; i < n; i++) begin
            sdi = 1'b0;
            tick(HP);
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic cs_hi();
        tick(HP);
        cs_n = 1'b1;
        tick(4 * HP);
    endtask

    task automatic simple(input logic [7:0] op);
        logic [7:0] r;
        cs_lo(); xbyte(op, r); cs_hi();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] r;
        cs_lo(); xbyte(8'h05, r); xbyte(8'h00, s); cs_hi();
    endtask

    task automatic wait_idle(output logic [7:0] first);
        logic [7:0] r, s;
        int n;
        cs_lo(); xbyte(8'h05, r); xbyte(8'h00, first);
        s = first; n = 0;
        while (s[0] && n < 100) begin
            xbyte(8'h00, s);
            n++;
        end
        cs_hi();
        chk("R2 streamed status ends idle", {7'd0, s[0]}, 8'h00);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r;
        xbyte(a[23:16], r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    endtask

    task automatic read_mem(input string tag, input logic [23:0] a, input int n, input logic fast);
        logic [7:0] r;
        cs_lo();
        xbyte(fast ? 8'h0B : 8'h03, r);
        send_addr(a);
        if (fast) xbyte(8'h00, r);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            chk(tag, r, ref_mem[(int'(a) + i) % DEPTH]);
        end
        cs_hi();
    endtask

    task automatic wstat(input logic [7:0] d);
        logic [7:0] r;
        cs_lo(); xbyte(8'h01, r); xbyte(d, r); cs_hi();
        if (ref_wel) begin
            ref_shi = d[7:2];
            ref_wel = 1'b0;
        end
    endtask

    task automatic prog(input logic [23:0] a, input int extra);
        logic [7:0] r;
        logic [7:0] bm [PAGE];
        int len;
        cs_lo(); xbyte(8'h02, r); send_addr(a);
        foreach (dq[i]) xbyte(dq[i], r);
        extra_bits(extra);
        cs_hi();
        if (ref_wel && (extra % 8) == 0 && dq.size() > 0) begin
            foreach (dq[i]) bm[i % PAGE] = dq[i];
            len = (dq.size() < PAGE) ? dq.size() : PAGE;
            for (int i = 0; i < len; i++)
                ref_mem[(int'(a) + i) % DEPTH] = ref_mem[(int'(a) + i) % DEPTH] & bm[i];
            ref_wel = 1'b0;
        end
    endtask

    initial begin
        logic [7:0] s, r;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        tick(10);
        rst_n = 1'b1;
        tick(10);

        chk("R1 serial output after reset", {7'd0, sdo}, 8'h00);
        rd_status(s);
        chk("R1 R2 status after reset", s, 8'h00);
        read_mem("R1 array erased after reset", 24'h000000, 2, 1'b0);

        simple(8'h06); ref_wel = 1'b1;
        rd_status(s); chk("R5 write enable sets latch", s, ref_status());
        simple(8'h04); ref_wel = 1'b0;
        rd_status(s); chk("R5 write disable clears latch", s, ref_status());
        cs_lo(); xbyte(8'h06, r); extra_bits(1); cs_hi();
        rd_status(s); chk("R5 enable off byte boundary ignored", s, ref_status());

        wstat(8'hFC);
        rd_status(s); chk("R6 status write without latch ignored", s, ref_status());

        simple(8'h06); ref_wel = 1'b1;
        dq = {8'hA5, 8'h3C, 8'h0F};
        prog(24'h000010, 5);
        rd_status(s); chk("R7 misaligned program keeps latch", s, ref_status());
        read_mem("R7 misaligned program leaves array", 24'h000010, 3, 1'b0);

        prog(24'h000010, 0);
        wait_idle(s);
        chk("R10 R6 busy set, latch cleared", s & 8'h03, 8'h01);
        rd_status(s); chk("R10 busy ends", s, ref_status());
        read_mem("R3 R8 program and read back", 24'h000010, 4, 1'b0);

        simple(8'h06); ref_wel = 1'b1;
        dq = {8'hF0};
        prog(24'h000010, 0);
        wait_idle(s);
        read_mem("R8 program ANDs with old value", 24'h000010, 1, 1'b0);
        chk("R8 AND result", ref_mem[16], 8'hA0);

        read_mem("R3 address truncation wraps", 24'hFFFF3E, 4, 1'b0);
        read_mem("R4 fast read with dummy byte", 24'h000011, 2, 1'b1);

        cs_lo(); xbyte(8'hAB, r); send_addr(24'h000000);
        xbyte(8'h00, r); chk("R4 ID byte first", r, IDB);
        xbyte(8'h00, r); chk("R4 ID byte repeats", r, IDB);
        cs_hi();

        simple(8'h06); ref_wel = 1'b1;
        wstat(8'hFC);
        simple(8'h06);              // lands in the busy window, ignored
        wait_idle(s);
        rd_status(s); chk("R10 R2 enable during busy ignored", s, ref_status());

        simple(8'h06); ref_wel = 1'b1;
        dq = {8'h00};
        prog(24'h000030, 0);
        cs_lo(); xbyte(8'h03, r); send_addr(24'h000010);
        xbyte(8'h00, r); chk("R10 read during busy gives no data", r, 8'h00);
        cs_hi();
        wait_idle(s);
        read_mem("R10 program during busy completes", 24'h000030, 1, 1'b0);

        simple(8'h06); ref_wel = 1'b1;
        dq.delete();
        for (int i = 0; i < 18; i++) dq.push_back(8'((i * 37 + 5) & 8'hFF));
        prog(24'h000020, 0);
        wait_idle(s);
        read_mem("R8 page buffer wraps", 24'h000020, 16, 1'b0);

        cs_lo(); xbyte(8'h9F, r); xbyte(8'h00, r);
        chk("R11 unknown opcode output", r, 8'h00);
        cs_hi();
        rd_status(s); chk("R11 unknown opcode leaves status", s, ref_status());

        simple(8'hC7);
        read_mem("R6 erase without latch ignored", 24'h000010, 1, 1'b0);

        simple(8'h06); ref_wel = 1'b1;
        simple(8'hC7);
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        ref_wel = 1'b0;
        wait_idle(s);
        chk("R9 R10 erase sets busy", s & 8'h03, 8'h01);
        read_mem("R9 erase clears data", 24'h000010, 3, 1'b0);
        read_mem("R9 erase clears page", 24'h000020, 2, 1'b0);
        read_mem("R9 erase clears byte", 24'h000030, 1, 1'b0);
        chk("R11 output idle after frames", {7'd0, sdo}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule